// File: doc/BRIEF.md
# Header Field Segmenter

The segmenter sits behind the parse-control logic of a streaming packet parser. Packet data arrives as one 64-bit word per cycle and is never buffered. With each word comes a segmentation micro-instruction. In extract mode the instruction carries up to four field descriptors. Each descriptor names a byte position within the word, a width code and a destination container slot. The block copies every valid field, right-justified, into its own slot of the output container vector. Two fields never share a slot.

Every extracted group is tagged with three items: the ingress port, the byte offset of the word from the start of the packet, and a user tag taken from the instruction. In payload mode the same instruction can repeat for as many cycles as the payload lasts. Each word is forwarded raw to a shared data buffer, and a remaining-byte counter updates on its own. Forwarding ends at whichever comes first: the counter running out or the end-of-packet flag. The final word reports how many of its bytes are valid.

The output of both paths is registered, one cycle after the input word. Choosing the next instruction is left to the surrounding parse-control logic.

Top module: `hdr_segmenter`

## Requirements
- R1: While `rst_n` is low, and after its release until a word is accepted, `out_valid`, `pl_valid` and every bit of `out_slot_vld` are 0.
- R2: In extract mode (`ins_mode`=0), byte k of a word is `in_data[63-8k -: 8]`, so byte 0 is the most significant. A field at byte position o with width code w is bytes o through o+B-1 of the word, packed big-endian and right-justified in its container. Width code 0, 1, 2 and 3 gives B = 1, 2, 4 and 8 bytes. The result appears on the clock edge after the word is accepted.
- R3: A fitting field goes to the slot given by its destination index. That slot's `out_slot_vld` bit is set and its 2-bit `out_slot_wc` holds the field's width code. Slots that receive no field have valid, width code and data all equal to 0.
- R4: A field for which o+B exceeds 8 is not written to any slot, and `out_err` is set for that group.
- R5: When two or more fitting fields name the same slot, the field with the lowest descriptor index fills the slot and `out_err` is set.
- R6: `out_port` and `out_tag` repeat the port and tag presented with the word. `out_offset` is the byte offset of the word within its packet. It is 0 for a word with `in_sop` set, and every accepted word (`in_valid`, either mode) advances it by 8.
- R7: In payload mode (`ins_mode`=1) with a nonzero remaining count, the word appears unchanged on `pl_data` one cycle later, and the remaining count drops by 8.
- R8: When the remaining count is 8 or less, the word is marked `pl_last`, `pl_bytes` equals the count, and the count becomes 0. A payload-mode word that arrives while the count is 0 produces no `pl_valid`.
- R9: A payload word with `in_eop` set is marked last. Its `pl_bytes` is the smaller of `in_bytes` (1 to 8) and the remaining count, and the count is cleared. Any `pl_valid` that follows an end-of-packet payload word carries `pl_last`.
- R10: `ins_len_load` writes `ins_len` into the remaining count, which takes effect from the next cycle. A payload word in the same cycle is measured against the old count.
- R11: An extract-mode word produces no `pl_valid`, and a payload-mode word produces no `out_valid`. A cycle with `in_valid` low produces neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Packet word present |
| in_sop | input | 1 | Word is the first of its packet |
| in_eop | input | 1 | Word is the last of its packet |
| in_bytes | input | 4 | Valid bytes in an end-of-packet word (1 to 8) |
| in_data | input | 64 | Packet word, byte 0 in the top bits |
| in_port | input | 4 | Ingress port of the packet |
| ins_mode | input | 1 | 0 extract, 1 payload forward |
| ins_fld_en | input | 4 | Per-descriptor enable |
| ins_fld_off | input | 12 | Byte position per descriptor, 3 bits each |
| ins_fld_wc | input | 8 | Width code per descriptor, 2 bits each |
| ins_fld_dst | input | 8 | Destination slot per descriptor, 2 bits each |
| ins_tag | input | 8 | User tag for the extracted group |
| ins_len_load | input | 1 | Load the remaining payload byte count |
| ins_len | input | 16 | Value for the remaining count |
| out_valid | output | 1 | Container group present |
| out_slot_vld | output | 4 | Per-slot valid |
| out_slot_data | output | 256 | Slot contents, slot s at bits 64s+63:64s |
| out_slot_wc | output | 8 | Per-slot width code, slot s at bits 2s+1:2s |
| out_port | output | 4 | Ingress port metadata |
| out_offset | output | 16 | Packet byte offset metadata |
| out_tag | output | 8 | User tag metadata |
| out_err | output | 1 | Overflowing field or slot collision in the group |
| pl_valid | output | 1 | Payload word present |
| pl_data | output | 64 | Payload word |
| pl_bytes | output | 4 | Valid bytes in the payload word |
| pl_last | output | 1 | Final word of the payload |

## Verification
The bench places fields at the far edge of the word: a one-byte field at position 7, a full-word field, and a two-byte field at position 7 that overflows. A slicer with an off-by-one shift would return the neighbouring byte, and one that ignores the boundary would leak bytes that do not belong to the word into a slot. Two fields aimed at one slot check that the lower descriptor is the one kept, which catches a reversed priority. The payload runs end on a short tail, on an end-of-packet word whose valid bytes are fewer than the budget, and on an end-of-packet word whose valid bytes exceed it. After a payload has ended, words are sent with a zero budget. A counter that never stops would send them on, and one that ignores the end-of-packet flag would report wrong byte counts. A count loaded in the same cycle as a payload word would shorten that word if the load took effect too early.

// File: rtl/seg_pkg.sv
// Package: shared types and helpers for the header field segmenter.
// Assumes width codes are 2 bits, each selecting a power-of-two byte count.
package seg_pkg;

    typedef enum logic {
        MODE_EXTRACT = 1'b0,
        MODE_PAYLOAD = 1'b1
    } seg_mode_e;

    // Number of bytes selected by a 2-bit width code (1, 2, 4, 8).
    function automatic int wc_bytes(input logic [1:0] wc);
        return 1 << int'(wc);
    endfunction

endpackage

// File: rtl/seg_field_unit.sv
// Module: one field slicer. It cuts the bytes named by a single descriptor out
// of the current word and right-justifies them. It is purely combinational.
// Assumes byte 0 sits in the most significant bits of the word.
module seg_field_unit #(
    parameter int DATA_W = 64,
    localparam int BYTES = DATA_W / 8,
    localparam int BOFF_W = $clog2(BYTES)
) (
    input  logic [DATA_W-1:0] word,
    input  logic              en,
    input  logic [BOFF_W-1:0] boff,
    input  logic [1:0]        wc,
    output logic              hit,
    output logic              err,
    output logic [DATA_W-1:0] value
);
    import seg_pkg::*;

    logic [DATA_W-1:0] shl;
    logic              fits;
    int                nb;

    // Check the field stays inside the word and align it to bit 0.
    always_comb begin
        nb    = wc_bytes(wc);
        fits  = (int'(boff) + nb) <= BYTES;
        shl   = word << (8 * int'(boff));
        value = fits ? (shl >> (DATA_W - 8 * nb)) : '0;
        hit   = en && fits;
        err   = en && !fits;
    end

endmodule

// File: rtl/seg_payload_fwd.sv
// Module: payload forwarder. It passes raw words to the shared data buffer
// while a remaining-byte budget lasts, ending on budget exhaustion or on
// end of packet. Assumes in_bytes lies in 1..BYTES whenever eop is set.
module seg_payload_fwd #(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 16,
    localparam int BYTES = DATA_W / 8,
    localparam int CNT_W = $clog2(BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwd_req,
    input  logic              eop,
    input  logic [CNT_W-1:0]  in_bytes,
    input  logic [DATA_W-1:0] data,
    input  logic              len_load,
    input  logic [LEN_W-1:0]  len,
    output logic              pl_valid,
    output logic [DATA_W-1:0] pl_data,
    output logic [CNT_W-1:0]  pl_bytes,
    output logic              pl_last
);
    logic [LEN_W-1:0] rem_q;
    logic             go;
    logic             rem_le;
    logic             last;
    logic [CNT_W-1:0] by_len;
    logic [CNT_W-1:0] nbytes;

    // Decide whether this word goes out, and with how many bytes.
    always_comb begin
        go     = fwd_req && (rem_q != '0);
        rem_le = rem_q <= LEN_W'(BYTES);
        by_len = rem_le ? rem_q[CNT_W-1:0] : CNT_W'(BYTES);
        nbytes = (eop && (in_bytes < by_len)) ? in_bytes : by_len;
        last   = eop || rem_le;
    end

    // Remaining-byte budget: a load wins, otherwise count down per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (len_load) begin
            rem_q <= len;
        end else if (go) begin
            rem_q <= last ? '0 : rem_q - LEN_W'(BYTES);
        end
    end

    // Register the forwarded word toward the data buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pl_valid <= 1'b0;
            pl_data  <= '0;
            pl_bytes <= '0;
            pl_last  <= 1'b0;
        end else begin
            pl_valid <= go;
            if (go) begin
                pl_data  <= data;
                pl_bytes <= nbytes;
                pl_last  <= last;
            end
        end
    end

endmodule

// File: rtl/hdr_segmenter.sv
// Module: header field segmenter (top). Per word, it either slices up to NFLD
// fields into NSLOT fixed containers with port/offset/tag metadata, or
// forwards the word as payload. Assumes one word per cycle and no stalls.
module hdr_segmenter #(
    parameter int DATA_W = 64,
    parameter int NFLD   = 4,
    parameter int NSLOT  = 4,
    parameter int PORT_W = 4,
    parameter int TAG_W  = 8,
    parameter int OFF_W  = 16,
    parameter int LEN_W  = 16,
    localparam int BYTES  = DATA_W / 8,
    localparam int BOFF_W = $clog2(BYTES),
    localparam int SLOT_W = $clog2(NSLOT),
    localparam int CNT_W  = $clog2(BYTES) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sop,
    input  logic                    in_eop,
    input  logic [CNT_W-1:0]        in_bytes,
    input  logic [DATA_W-1:0]       in_data,
    input  logic [PORT_W-1:0]       in_port,
    input  logic                    ins_mode,
    input  logic [NFLD-1:0]         ins_fld_en,
    input  logic [NFLD*BOFF_W-1:0]  ins_fld_off,
    input  logic [NFLD*2-1:0]       ins_fld_wc,
    input  logic [NFLD*SLOT_W-1:0]  ins_fld_dst,
    input  logic [TAG_W-1:0]        ins_tag,
    input  logic                    ins_len_load,
    input  logic [LEN_W-1:0]        ins_len,
    output logic                    out_valid,
    output logic [NSLOT-1:0]        out_slot_vld,
    output logic [NSLOT*DATA_W-1:0] out_slot_data,
    output logic [NSLOT*2-1:0]      out_slot_wc,
    output logic [PORT_W-1:0]       out_port,
    output logic [OFF_W-1:0]        out_offset,
    output logic [TAG_W-1:0]        out_tag,
    output logic                    out_err,
    output logic                    pl_valid,
    output logic [DATA_W-1:0]       pl_data,
    output logic [CNT_W-1:0]        pl_bytes,
    output logic                    pl_last
);
    import seg_pkg::*;

    seg_mode_e         mode;
    logic              ext_go;
    logic              pay_req;
    logic [NFLD-1:0]   fld_hit;
    logic [NFLD-1:0]   fld_err;
    logic [DATA_W-1:0] fld_val [NFLD];
    logic [SLOT_W-1:0] fld_dst [NFLD];
    logic [1:0]        fld_wc  [NFLD];

    logic [NSLOT-1:0]        nxt_vld;
    logic [NSLOT*DATA_W-1:0] nxt_data;
    logic [NSLOT*2-1:0]      nxt_wc;
    logic                    coll;
    logic [OFF_W-1:0]        off_q;
    logic [OFF_W-1:0]        cur_off;

    // Decode the mode and the per-cycle enables.
    always_comb begin
        mode    = seg_mode_e'(ins_mode);
        ext_go  = in_valid && (mode == MODE_EXTRACT);
        pay_req = in_valid && (mode == MODE_PAYLOAD);
        cur_off = in_sop ? '0 : off_q;
    end

    // One slicer for each descriptor.
    for (genvar f = 0; f < NFLD; f++) begin : g_fld
        assign fld_dst[f] = ins_fld_dst[f*SLOT_W +: SLOT_W];
        assign fld_wc[f]  = ins_fld_wc[f*2 +: 2];

        seg_field_unit #(.DATA_W(DATA_W)) u_fu (
            .word  (in_data),
            .en    (ins_fld_en[f]),
            .boff  (ins_fld_off[f*BOFF_W +: BOFF_W]),
            .wc    (fld_wc[f]),
            .hit   (fld_hit[f]),
            .err   (fld_err[f]),
            .value (fld_val[f])
        );
    end

    // Route fields to slots: the lowest descriptor index wins, and sharing a slot is an error.
    always_comb begin
        nxt_vld  = '0;
        nxt_data = '0;
        nxt_wc   = '0;
        coll     = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            int cnt;
            cnt = 0;
            for (int f = 0; f < NFLD; f++) begin
                if (fld_hit[f] && (fld_dst[f] == SLOT_W'(s))) cnt++;
            end
            if (cnt > 1) coll = 1'b1;
            for (int f = NFLD - 1; f >= 0; f--) begin
                if (fld_hit[f] && (fld_dst[f] == SLOT_W'(s))) begin
                    nxt_vld[s]                 = 1'b1;
                    nxt_data[s*DATA_W +: DATA_W] = fld_val[f];
                    nxt_wc[s*2 +: 2]           = fld_wc[f];
                end
            end
        end
    end

    // Packet byte offset: restart at the start of packet, advance per accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (in_valid) begin
            off_q <= cur_off + OFF_W'(BYTES);
        end
    end

    // Register the container vector and its metadata.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_slot_vld  <= '0;
            out_slot_data <= '0;
            out_slot_wc   <= '0;
            out_port      <= '0;
            out_offset    <= '0;
            out_tag       <= '0;
            out_err       <= 1'b0;
        end else begin
            out_valid    <= ext_go;
            out_slot_vld <= ext_go ? nxt_vld : '0;
            if (ext_go) begin
                out_slot_data <= nxt_data;
                out_slot_wc   <= nxt_wc;
                out_port      <= in_port;
                out_offset    <= cur_off;
                out_tag       <= ins_tag;
                out_err       <= (|fld_err) || coll;
            end else begin
                out_err       <= 1'b0;
            end
        end
    end

    // Payload path toward the shared data buffer.
    seg_payload_fwd #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_pay (
        .clk      (clk),
        .rst_n    (rst_n),
        .fwd_req  (pay_req),
        .eop      (in_eop),
        .in_bytes (in_bytes),
        .data     (in_data),
        .len_load (ins_len_load),
        .len      (ins_len),
        .pl_valid (pl_valid),
        .pl_data  (pl_data),
        .pl_bytes (pl_bytes),
        .pl_last  (pl_last)
    );

endmodule

// File: rtl/seg_checker.sv
// Module: property checker for hdr_segmenter, attached with bind below.
// Assumes it sees only the top module's ports.
module seg_checker #(
    parameter int NSLOT = 4,
    parameter int OFF_W = 16,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sop,
    input logic             in_eop,
    input logic             ins_mode,
    input logic             out_valid,
    input logic [NSLOT-1:0] out_slot_vld,
    input logic [OFF_W-1:0] out_offset,
    input logic             out_err,
    input logic             pl_valid,
    input logic [CNT_W-1:0] pl_bytes,
    input logic             pl_last
);

    p_slot_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_slot_vld == '0));

    p_err_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid);

    p_sop_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && !ins_mode) |=> (out_offset == '0));

    p_offset_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_offset[2:0] == 3'd0));

    p_full_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && !pl_last) |-> (pl_bytes == CNT_W'(8)));

    p_bytes_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pl_valid |-> ((pl_bytes >= CNT_W'(1)) && (pl_bytes <= CNT_W'(8))));

    p_eop_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eop && ins_mode) |=> (!pl_valid || pl_last));

    p_mode_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && pl_valid));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !pl_valid));

endmodule

bind hdr_segmenter seg_checker #(
    .NSLOT (NSLOT),
    .OFF_W (OFF_W),
    .CNT_W (CNT_W)
) u_seg_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_sop       (in_sop),
    .in_eop       (in_eop),
    .ins_mode     (ins_mode),
    .out_valid    (out_valid),
    .out_slot_vld (out_slot_vld),
    .out_offset   (out_offset),
    .out_err      (out_err),
    .pl_valid     (pl_valid),
    .pl_bytes     (pl_bytes),
    .pl_last      (pl_last)
);

// File: tb/sim_hdr_segmenter.sv
module sim_hdr_segmenter;

    typedef struct packed {
        logic [3:0]   sv;
        logic [255:0] sd;
        logic [7:0]   wc;
        logic [3:0]   port;
        logic [15:0]  off;
        logic [7:0]   tag;
        logic         err;
    } exp_c_t;

    typedef struct packed {
        logic [63:0] data;
        logic [3:0]  bytes;
        logic        last;
    } exp_p_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [3:0]   in_bytes = '0;
    logic [63:0]  in_data = '0;
    logic [3:0]   in_port = '0;
    logic         ins_mode = 1'b0;
    logic [3:0]   ins_fld_en = '0;
    logic [11:0]  ins_fld_off = '0;
    logic [7:0]   ins_fld_wc = '0;
    logic [7:0]   ins_fld_dst = '0;
    logic [7:0]   ins_tag = '0;
    logic         ins_len_load = 1'b0;
    logic [15:0]  ins_len = '0;
    logic         out_valid;
    logic [3:0]   out_slot_vld;
    logic [255:0] out_slot_data;
    logic [7:0]   out_slot_wc;
    logic [3:0]   out_port;
    logic [15:0]  out_offset;
    logic [7:0]   out_tag;
    logic         out_err;
    logic         pl_valid;
    logic [63:0]  pl_data;
    logic [3:0]   pl_bytes;
    logic         pl_last;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    exp_c_t cq[$];
    exp_p_t pq[$];
    logic [15:0] m_off = '0;
    logic [15:0] m_rem = '0;

    always #5 clk = ~clk;

    hdr_segmenter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_bytes(in_bytes), .in_data(in_data),
        .in_port(in_port), .ins_mode(ins_mode), .ins_fld_en(ins_fld_en),
        .ins_fld_off(ins_fld_off), .ins_fld_wc(ins_fld_wc),
        .ins_fld_dst(ins_fld_dst), .ins_tag(ins_tag),
        .ins_len_load(ins_len_load), .ins_len(ins_len),
        .out_valid(out_valid), .out_slot_vld(out_slot_vld),
        .out_slot_data(out_slot_data), .out_slot_wc(out_slot_wc),
        .out_port(out_port), .out_offset(out_offset), .out_tag(out_tag),
        .out_err(out_err), .pl_valid(pl_valid), .pl_data(pl_data),
        .pl_bytes(pl_bytes), .pl_last(pl_last)
    );

    function automatic logic [63:0] pick(input logic [63:0] d, input int o, input int nb);
        logic [63:0] v;
        v = '0;
        for (int k = 0; k < nb; k++) v = (v << 8) | 64'(d[63 - 8 * (o + k) -: 8]);
        return v;
    endfunction

    // Driver: build the expected result from the model, then present one word.
    task automatic cyc(input logic v, input logic sop, input logic eop, input logic [3:0] ib,
                       input logic [63:0] d, input logic mode, input logic [3:0] en,
                       input logic [11:0] off, input logic [7:0] wc, input logic [7:0] dst,
                       input logic [3:0] port, input logic [7:0] tag,
                       input logic ld, input logic [15:0] len);
        exp_c_t c;
        exp_p_t p;
        if (v) begin
            logic [15:0] woff;
            woff = sop ? 16'd0 : m_off;
            if (!mode) begin
                c = '0;
                c.port = port; c.off = woff; c.tag = tag;
                for (int f = 0; f < 4; f++) begin
                    if (en[f]) begin
                        int o, nb, s;
                        o  = int'(off[f*3 +: 3]);
                        nb = 1 << int'(wc[f*2 +: 2]);
                        s  = int'(dst[f*2 +: 2]);
                        if (o + nb > 8) c.err = 1'b1;          // R4
                        else if (c.sv[s]) c.err = 1'b1;        // R5: earlier index kept
                        else begin
                            c.sv[s] = 1'b1;
                            c.sd[s*64 +: 64] = pick(d, o, nb);
                            c.wc[s*2 +: 2] = wc[f*2 +: 2];
                        end
                    end
                end
                cq.push_back(c);
            end else if (m_rem != 16'd0) begin
                int nbv;
                nbv = (m_rem <= 16'd8) ? int'(m_rem) : 8;
                if (eop && int'(ib) < nbv) nbv = int'(ib);
                p.data = d; p.bytes = 4'(nbv); p.last = eop || (m_rem <= 16'd8);
                pq.push_back(p);
                m_rem = p.last ? 16'd0 : m_rem - 16'd8;
            end
            m_off = woff + 16'd8;
        end
        if (ld) m_rem = len;   // R10: effective for later words only
        in_valid = v; in_sop = sop; in_eop = eop; in_bytes = ib; in_data = d;
        ins_mode = mode; ins_fld_en = en; ins_fld_off = off; ins_fld_wc = wc;
        ins_fld_dst = dst; in_port = port; ins_tag = tag; ins_len_load = ld; ins_len = len;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input logic ld, input logic [15:0] len);
        cyc(1'b0, 1'b0, 1'b0, 4'd0, 64'd0, 1'b0, 4'd0, 12'd0, 8'd0, 8'd0, 4'd0, 8'd0, ld, len);
    endtask

    task automatic pay(input logic sop, input logic eop, input logic [3:0] ib,
                       input logic [63:0] d, input logic ld, input logic [15:0] len);
        cyc(1'b1, sop, eop, ib, d, 1'b1, 4'd0, 12'd0, 8'd0, 8'd0, 4'd0, 8'd0, ld, len);
    endtask

    // Monitor: pop and compare whenever the design produces a result.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_c_t a, e;
            a = {out_slot_vld, out_slot_data, out_slot_wc, out_port, out_offset, out_tag, out_err};
            checks++;
            if (cq.size() == 0) begin
                errors++;
                $display("FAIL R11/R2: unexpected container group, actual=%h expected=none", a);
            end else begin
                e = cq.pop_front();
                if (a !== e) begin
                    errors++;
                    $display("FAIL R2/R3/R4/R5/R6: container actual=%h expected=%h", a, e);
                end
            end
        end
        if (rst_n && pl_valid) begin
            exp_p_t a, e;
            a = {pl_data, pl_bytes, pl_last};
            checks++;
            if (pq.size() == 0) begin
                errors++;
                $display("FAIL R8/R11: unexpected payload word, actual=%h expected=none", a);
            end else begin
                e = pq.pop_front();
                if (a !== e) begin
                    errors++;
                    $display("FAIL R7/R8/R9/R10: payload actual=%h expected=%h", a, e);
                end
            end
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] w;
        w = 64'h0011_2233_4455_6677;
        repeat (3) @(posedge clk);
        #4;
        // R1: quiet during reset
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(pl_valid == 1'b0, "R1 pl_valid", int'(pl_valid), 0);
        chk(out_slot_vld == 4'd0, "R1 slot_vld", int'(out_slot_vld), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(out_valid == 1'b0 && pl_valid == 1'b0, "R1 after release", int'(out_valid), 0);

        // R2/R3/R6: four fields, last one at byte 7
        cyc(1, 1, 0, 0, w, 0, 4'b1111, {3'd7, 3'd6, 3'd2, 3'd0}, {2'd0, 2'd0, 2'd2, 2'd1},
            {2'd3, 2'd2, 2'd1, 2'd0}, 4'd3, 8'hA1, 0, 0);
        // R2 full word into slot 3, R4 overflow of 16 bits at byte 7
        cyc(1, 0, 0, 0, 64'hDEAD_BEEF_0102_0304, 0, 4'b0011, {6'd0, 3'd7, 3'd0},
            {4'd0, 2'd1, 2'd3}, {4'd0, 2'd0, 2'd3}, 4'd3, 8'hA2, 0, 0);
        // R5: fields 0 and 2 both aim at slot 2
        cyc(1, 0, 0, 0, w, 0, 4'b0101, {3'd0, 3'd3, 3'd0, 3'd1}, {2'd0, 2'd1, 2'd0, 2'd0},
            {2'd0, 2'd2, 2'd0, 2'd2}, 4'd3, 8'hA3, 0, 0);
        // R3: no fields, metadata only
        cyc(1, 0, 0, 0, w, 0, 4'b0000, 12'd0, 8'd0, 8'd0, 4'd3, 8'hA4, 0, 0);
        idle(0, 0);                             // R11: nothing out
        idle(1, 16'd20);                        // R10 load
        pay(0, 0, 0, 64'h1111_1111_1111_1111, 0, 0);   // R7
        pay(0, 0, 0, 64'h2222_2222_2222_2222, 0, 0);   // R7
        pay(0, 0, 0, 64'h3333_3333_3333_3333, 0, 0);   // R8 tail of 4
        pay(0, 0, 0, 64'h4444_4444_4444_4444, 0, 0);   // R8 dropped
        idle(1, 16'd100);
        pay(0, 0, 0, 64'h5555_5555_5555_5555, 0, 0);
        pay(0, 0, 0, 64'h6666_6666_6666_6666, 1, 16'd5); // R10: uses old count
        pay(0, 0, 0, 64'h7777_7777_7777_7777, 0, 0);   // 5 bytes, last
        // R6: new packet offset restarts, port changes
        cyc(1, 1, 0, 0, w, 0, 4'b0001, 12'd4, 8'd1, 8'd1, 4'd5, 8'hB0, 0, 0);
        cyc(1, 0, 0, 0, w, 0, 4'b0001, 12'd0, 8'd2, 8'd0, 4'd5, 8'hB1, 1, 16'd40);
        pay(0, 0, 0, 64'h8888_8888_8888_8888, 0, 0);
        pay(0, 1, 4'd3, 64'h9999_9999_9999_9999, 0, 0); // R9: 3 bytes
        pay(0, 0, 0, 64'hAAAA_AAAA_AAAA_AAAA, 0, 0);   // R9: cleared, dropped
        idle(1, 16'd6);
        pay(1, 1, 4'd8, 64'hBBBB_BBBB_BBBB_BBBB, 0, 0); // R9: min gives 6
        idle(1, 16'd16);
        // R11: extract word while budget is live does not forward
        cyc(1, 1, 0, 0, w, 0, 4'b0001, 12'd0, 8'd0, 8'd0, 4'd1, 8'hC0, 0, 0);
        pay(0, 0, 0, 64'hCCCC_CCCC_CCCC_CCCC, 0, 0);
        idle(0, 0);
        idle(0, 0);
        idle(0, 0);
        // R8/R11: every expected item was produced, none left over
        chk(cq.size() == 0, "R11 container queue drained", cq.size(), 0);
        chk(pq.size() == 0, "R8 payload queue drained", pq.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule